// File: doc/BRIEF.md
# Misaligned Load Access Sequencer

This block serves byte-addressed loads of 1, 2, 4 or 8 bytes at any address, aligned or not. Each request is sorted into one of four span cases using only the low address bits and the size code. The block then reads one port word or two neighbouring port words from a banked, pattern-filled data array inside the block, and checks read permission in a per-page table. The fetched bytes are rotated and masked into a right-justified result, which is sign-extended or zero-extended on request.

Three of the span cases finish in a single array access. When the two neighbouring words sit on the same line, both banks use the same row. When they sit on adjacent lines, the bank holding the second word reads the next row. Only an access that crosses a page boundary takes two access cycles: the lower page first, then the upper page. Both pages are checked, and a fault is raised if either page denies the read. An atomic request that is not naturally aligned is refused with a fault and is never split. Requests and responses each use a valid/ready handshake, and only one request is in flight at a time.

Top module: `misaligned_load_seq`

## Requirements
- R1: Coming out of reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Size code s selects 2^s bytes. The array byte at wrapped address a holds ((a XOR (a >> 5)) * 29 + 7) mod 256. The result packs the byte at the request address into bits 7:0, followed by higher addresses. An access contained in one port word answers with `rsp_valid` one cycle after acceptance.
- R3: An access that crosses a port-word boundary inside one line returns the correct bytes one cycle after acceptance.
- R4: An access that crosses a line boundary inside one page returns the correct bytes, taken partly from the next line, one cycle after acceptance.
- R5: An access that crosses a page boundary answers two cycles after acceptance, and `req_ready` is low in the cycle between acceptance and response.
- R6: `rsp_fault` is 1 when any page touched by the access is marked unreadable in `PAGE_READ_OK` (bit p is page p). For a page-crossing access, both pages are checked.
- R7: Whenever `rsp_fault` is 1, `rsp_data` is zero.
- R8: With `req_signed` at 1, the bits above the access size copy the top bit of the highest byte. With `req_signed` at 0, those bits are zero.
- R9: An atomic request whose address is not a multiple of its size answers one cycle after acceptance with `rsp_fault` at 1, even if it would cross a page.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds its data and fault unchanged, and `req_ready` stays low.
- R11: An access that runs past the top address continues at address 0, and its upper page is page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code, 2^code bytes |
| req_signed | input | 1 | 1 selects sign extension |
| req_atomic | input | 1 | Request is atomic |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Right-justified, extended load data |
| rsp_fault | output | 1 | Permission or alignment fault |

## Verification
The bench builds the block with 8-byte ports, 32-byte lines, 128-byte pages and four pages, with page 2 unreadable. This gives a 512-byte address space, so every address can be swept with every size, both extension modes and the atomic flag. At that size, all four span cases, page crossings into and out of the forbidden page, and the wrap from the top address back to page 0 occur many times each. Response latency and back-pressure holding are measured at the ports.

// File: rtl/mls_pkg.sv
package mls_pkg;

    localparam int RES_W = 64;

    typedef enum logic [1:0] {
        SPAN_ONE_PORT = 2'd0,
        SPAN_TWO_PORT = 2'd1,
        SPAN_TWO_LINE = 2'd2,
        SPAN_TWO_PAGE = 2'd3
    } span_e;

    // Content of the pattern-filled array at a wrapped byte address.
    function automatic logic [7:0] fill_byte(input logic [31:0] a);
        logic [31:0] mix;
        mix = ((a ^ (a >> 5)) * 32'd29) + 32'd7;
        return mix[7:0];
    endfunction

endpackage

// File: rtl/mls_classifier.sv
module mls_classifier
    import mls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    localparam int PORT_LSB  = $clog2(PORT_BYTES),
    localparam int LINE_LSB  = $clog2(LINE_BYTES),
    localparam int PAGE_LSB  = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_LSB-1:0] addr_in_page,
    input  logic [1:0]          size_code,
    output span_e               span,
    output logic                natural_ok
);
    logic [PORT_LSB:0] last_off;
    logic [2:0]        size_mask;
    logic              cross_port;
    logic              last_bank;
    logic              last_line;

    always_comb begin
        size_mask  = 3'((4'd1 << size_code) - 4'd1);
        last_off   = {1'b0, addr_in_page[PORT_LSB-1:0]} + (PORT_LSB+1)'(size_mask);
        cross_port = last_off[PORT_LSB];
        last_bank  = &addr_in_page[LINE_LSB-1:PORT_LSB];
        last_line  = &addr_in_page[PAGE_LSB-1:LINE_LSB];
        natural_ok = (addr_in_page[2:0] & size_mask) == 3'd0;
        if (!cross_port)     span = SPAN_ONE_PORT;
        else if (!last_bank) span = SPAN_TWO_PORT;
        else if (!last_line) span = SPAN_TWO_LINE;
        else                 span = SPAN_TWO_PAGE;
    end
endmodule

// File: rtl/mls_bank_fetch.sv
module mls_bank_fetch
    import mls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_PAGES  = 2,
    parameter logic [NUM_PAGES-1:0] PAGE_READ_OK = '1,
    parameter int ADDR_W     = $clog2(NUM_PAGES * PAGE_BYTES),
    localparam int PORT_LSB   = $clog2(PORT_BYTES),
    localparam int PW         = PORT_BYTES * 8,
    localparam int WA_W       = ADDR_W - PORT_LSB,
    localparam int BANKS      = LINE_BYTES / PORT_BYTES,
    localparam int BANK_W     = $clog2(BANKS),
    localparam int ROW_W      = WA_W - BANK_W,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES / PORT_BYTES)
) (
    input  logic [WA_W-1:0] word_addr,
    output logic [PW-1:0]   lo_word,
    output logic [PW-1:0]   hi_word,
    output logic            page_ok
);
    logic [BANK_W-1:0]          bank0;
    logic [BANK_W-1:0]          bank1;
    logic [ROW_W-1:0]           row0;
    logic [ROW_W-1:0]           row1;
    logic [BANKS-1:0][PW-1:0]   bank_word;

    assign bank0 = word_addr[BANK_W-1:0];
    assign bank1 = bank0 + BANK_W'(1);
    assign row0  = word_addr[WA_W-1:BANK_W];
    assign row1  = row0 + ROW_W'(1);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Banks below the first one hold the following port words on the next row.
        logic [ROW_W-1:0] row_sel;
        assign row_sel = (BANK_W'(b) >= bank0) ? row0 : row1;
        for (genvar j = 0; j < PORT_BYTES; j++) begin : g_byte
            logic [ADDR_W-1:0] byte_addr;
            assign byte_addr = {row_sel, BANK_W'(b), PORT_LSB'(j)};
            assign bank_word[b][8*j +: 8] = fill_byte(32'(byte_addr));
        end
    end

    assign lo_word = bank_word[bank0];
    assign hi_word = bank_word[bank1];
    assign page_ok = PAGE_READ_OK[word_addr[WA_W-1:PAGE_SHIFT]];
endmodule

// File: rtl/mls_aligner.sv
module mls_aligner
    import mls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    localparam int PORT_LSB  = $clog2(PORT_BYTES),
    localparam int PW        = PORT_BYTES * 8
) (
    input  logic [PW-1:0]       lo_word,
    input  logic [PW-1:0]       hi_word,
    input  logic [PORT_LSB-1:0] offset,
    input  logic [1:0]          size_code,
    input  logic                sext,
    output logic [RES_W-1:0]    result
);
    logic [2*PW-1:0]  rotated;
    logic [RES_W-1:0] window;
    logic             sign;
    logic [7:0]       fill;

    always_comb begin
        rotated = {hi_word, lo_word} >> {offset, 3'b000};
        window  = rotated[RES_W-1:0];
        case (size_code)
            2'd0:    sign = window[7];
            2'd1:    sign = window[15];
            2'd2:    sign = window[31];
            default: sign = window[63];
        endcase
        fill = {8{sext & sign}};
        for (int i = 0; i < RES_W / 8; i++) begin
            if (i < (1 << size_code)) result[8*i +: 8] = window[8*i +: 8];
            else                      result[8*i +: 8] = fill;
        end
    end
endmodule

// File: rtl/misaligned_load_seq.sv
module misaligned_load_seq
    import mls_pkg::*;
#(
    parameter int PORT_BYTES = 8,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_PAGES  = 2,
    parameter logic [NUM_PAGES-1:0] PAGE_READ_OK = '1,
    parameter int ADDR_W     = $clog2(NUM_PAGES * PAGE_BYTES),
    localparam int PORT_LSB  = $clog2(PORT_BYTES),
    localparam int PAGE_LSB  = $clog2(PAGE_BYTES),
    localparam int PW        = PORT_BYTES * 8,
    localparam int WA_W      = ADDR_W - PORT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_atomic,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [RES_W-1:0]  rsp_data,
    output logic              rsp_fault
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              sext;
        logic [PW-1:0]     lo_word;
        logic              lo_fault;
        logic              rsp_valid;
        logic [RES_W-1:0]  rsp_data;
        logic              rsp_fault;
    } state_t;

    state_t st_d, st_q;

    span_e             span;
    logic              natural_ok;
    logic              atomic_bad;
    logic              accept;
    logic [WA_W-1:0]   fetch_wa;
    logic [PW-1:0]     f_lo, f_hi;
    logic              f_ok;
    logic [PW-1:0]     al_lo, al_hi;
    logic [PORT_LSB-1:0] al_off;
    logic [1:0]        al_size;
    logic              al_sext;
    logic [RES_W-1:0]  al_res;
    logic              fault_now;

    mls_classifier #(
        .PORT_BYTES(PORT_BYTES), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_classifier (
        .addr_in_page(req_addr[PAGE_LSB-1:0]),
        .size_code   (req_size),
        .span        (span),
        .natural_ok  (natural_ok)
    );

    // Second cycle of a page crossing fetches the word after the stored one.
    assign fetch_wa = st_q.busy ? (st_q.addr[ADDR_W-1:PORT_LSB] + WA_W'(1))
                                : req_addr[ADDR_W-1:PORT_LSB];

    mls_bank_fetch #(
        .PORT_BYTES(PORT_BYTES), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES),
        .NUM_PAGES(NUM_PAGES), .PAGE_READ_OK(PAGE_READ_OK), .ADDR_W(ADDR_W)
    ) u_fetch (
        .word_addr(fetch_wa),
        .lo_word  (f_lo),
        .hi_word  (f_hi),
        .page_ok  (f_ok)
    );

    always_comb begin
        if (st_q.busy) begin
            al_lo   = st_q.lo_word;
            al_hi   = f_lo;
            al_off  = st_q.addr[PORT_LSB-1:0];
            al_size = st_q.size;
            al_sext = st_q.sext;
        end else begin
            al_lo   = f_lo;
            al_hi   = f_hi;
            al_off  = req_addr[PORT_LSB-1:0];
            al_size = req_size;
            al_sext = req_signed;
        end
    end

    mls_aligner #(.PORT_BYTES(PORT_BYTES)) u_aligner (
        .lo_word  (al_lo),
        .hi_word  (al_hi),
        .offset   (al_off),
        .size_code(al_size),
        .sext     (al_sext),
        .result   (al_res)
    );

    assign req_ready  = !st_q.busy && (!st_q.rsp_valid || rsp_ready);
    assign accept     = req_valid && req_ready;
    assign atomic_bad = req_atomic && !natural_ok;

    always_comb begin
        st_d      = st_q;
        fault_now = 1'b0;
        if (st_q.rsp_valid && rsp_ready) st_d.rsp_valid = 1'b0;
        if (st_q.busy) begin
            fault_now      = st_q.lo_fault || !f_ok;
            st_d.busy      = 1'b0;
            st_d.rsp_valid = 1'b1;
            st_d.rsp_fault = fault_now;
            st_d.rsp_data  = fault_now ? '0 : al_res;
        end else if (accept) begin
            if (atomic_bad) begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_fault = 1'b1;
                st_d.rsp_data  = '0;
            end else if (span == SPAN_TWO_PAGE) begin
                st_d.busy     = 1'b1;
                st_d.addr     = req_addr;
                st_d.size     = req_size;
                st_d.sext     = req_signed;
                st_d.lo_word  = f_lo;
                st_d.lo_fault = !f_ok;
            end else begin
                fault_now      = !f_ok;
                st_d.rsp_valid = 1'b1;
                st_d.rsp_fault = fault_now;
                st_d.rsp_data  = fault_now ? '0 : al_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign rsp_fault = st_q.rsp_fault;

    // R7
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_data == '0);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_fault));

    // R5
    page_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !atomic_bad && span == SPAN_TWO_PAGE |=> !req_ready && !rsp_valid);

    // R5
    page_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> rsp_valid);

    // R2
    single_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (atomic_bad || span != SPAN_TWO_PAGE) |=> rsp_valid);

    // R9
    atomic_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_atomic && natural_ok |-> span == SPAN_ONE_PORT);
endmodule

// File: tb/misaligned_load_seq_bench.sv
module misaligned_load_seq_bench;
    localparam int MEM   = 512;
    localparam int PAGE  = 128;
    localparam int LINE  = 32;
    localparam int PORT  = 8;
    localparam logic [3:0] OK_MAP = 4'b1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [8:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic        req_atomic = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_data;
    logic        rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    misaligned_load_seq #(
        .PORT_BYTES(PORT), .LINE_BYTES(LINE), .PAGE_BYTES(PAGE),
        .NUM_PAGES(4), .PAGE_READ_OK(OK_MAP)
    ) u_misaligned_load_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .req_atomic(req_atomic),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_fault(rsp_fault)
    );

    function automatic int pat(int a);
        int w;
        w = a % MEM;
        return (((w ^ (w >> 5)) * 29) + 7) & 255;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(int addr, int sz, bit sx, bit at);
        int nb, last, p0, p1, exp_lat, lat;
        bit bad, exp_fault;
        logic [63:0] exp_data;
        string tag;
        nb   = 1 << sz;
        last = addr + nb - 1;
        p0   = addr / PAGE;
        p1   = (last % MEM) / PAGE;
        bad  = at && (addr % nb != 0);
        if (bad)                                tag = "R9";
        else if ((addr % PORT) + nb <= PORT)    tag = "R2";
        else if (((addr / PORT) % 4) != 3)      tag = "R3";
        else if (((addr / LINE) % 4) != 3)      tag = "R4";
        else                                    tag = "R5";
        if (last >= MEM) tag = {tag, "/R11"};
        tag = $sformatf("%s addr=%0d size=%0d signed=%0d atomic=%0d", tag, addr, sz, sx, at);
        exp_lat   = (!bad && p0 != p1) ? 2 : 1;
        exp_fault = bad || !OK_MAP[p0] || !OK_MAP[p1];
        exp_data  = '0;
        if (!exp_fault) begin
            for (int i = 0; i < nb; i++) exp_data |= 64'(pat(addr + i)) << (8 * i);
            if (sx && nb < 8 && exp_data[8*nb-1]) exp_data |= ~64'd0 << (8 * nb);
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = 9'(addr); req_size = 2'(sz);
        req_signed = sx; req_atomic = at;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 5) begin
            // R5: no new request taken while the second page access runs
            check(req_ready == 1'b0, {"R5 ready-gap ", tag}, 64'(req_ready), 64'd0);
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {"latency ", tag}, 64'(lat), 64'(exp_lat));
        // R6 (R9 for atomic)
        check(rsp_fault == exp_fault, {"R6 fault ", tag}, 64'(rsp_fault), 64'(exp_fault));
        // R7 zero on fault, R8 extension
        check(rsp_data == exp_data, {exp_fault ? "R7 data " : "R8 data ", tag}, rsp_data, exp_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic        held_f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);

        for (int a = 0; a < MEM; a++)
            for (int s = 0; s < 4; s++)
                for (int x = 0; x < 2; x++)
                    run_req(a, s, x[0], 1'b0);
        for (int a = 0; a < MEM; a++)
            for (int s = 0; s < 4; s++)
                run_req(a, s, 1'b1, 1'b1);

        // R10: back-pressure on the response
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 9'd19; req_size = 2'd2; req_signed = 1'b1; req_atomic = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 9'd40;
        held   = rsp_data;
        held_f = rsp_fault;
        check(rsp_valid == 1'b1, "R10 response present", 64'(rsp_valid), 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1, "R10 valid held", 64'(rsp_valid), 64'd1);
            check(rsp_data == held && rsp_fault == held_f, "R10 data held", rsp_data, held);
            check(req_ready == 1'b0, "R10 ready low", 64'(req_ready), 64'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R10 drained", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule